// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one 16-pin general-purpose I/O port through a small synchronous register bus. Every pin owns a packed 4-bit configuration field. The low two bits give the direction and the drive speed class. The high two bits give the input flavour (analog, floating or pulled) or, for an output, the data source and the driver type. An output pin is driven either from the port's own output data register or from an alternate-function peripheral. The driver works as push-pull or open-drain.

The controller produces per-pin output-enable, output-value, weak pull-up enable, weak pull-down enable and a 2-bit speed class for external pad models. It registers all pad levels into an input data register on every clock. A set/clear register changes any group of output bits in one write, so software never needs a read-modify-write sequence. Reset puts every pin into floating input. Two parameters can bring chosen pins up with a pull-up or a pull-down instead.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A pin whose mode field (config bits [1:0]) is 00 is an input: pad_oe is 0 and its pad_speed pair is 00. Mode values 01, 10 and 11 make the pin an output, and its pad_speed pair equals the mode field (01 = 10 MHz class, 10 = 2 MHz class, 11 = 50 MHz class).
- R2: An output pin with config bits [3:2] = 00 (push-pull, register source) drives pad_oe = 1 and pad_out equal to its output data register bit.
- R3: An output pin with config bit 3 = 1 takes its value from af_in instead of the output data register.
- R4: An output pin with config bit 2 = 1 (open-drain) keeps pad_out at 0 and sets pad_oe to the inverse of its selected value, so a 1 releases the pad.
- R5: An input pin with config bits [3:2] = 10 enables pad_pu when its output data bit is 1 and pad_pd when that bit is 0. No pin ever has both pulls enabled, and output pins have neither.
- R6: An input pin with config bits [3:2] = 00 (analog) has both pulls off and reads 0 in the input data register. Bits 01 (floating) and the reserved 11 both leave the pulls off and read the pad level.
- R7: Writing the set/clear register (word 4) sets output data bits where wdata[15:0] is 1 and clears them where wdata[31:16] is 1. Set wins when both are 1 for one pin, zeros change nothing, and the register reads as 0.
- R8: The input data register (word 2, bits [15:0]) holds the pad_in levels captured at the previous rising clock edge.
- R9: After reset every configuration field is 4'h4 (floating input) and the output data register is 0. A pin marked in RST_PULLUP comes up as field 4'h8 with its data bit 1. A pin marked only in RST_PULLDN comes up as field 4'h8 with its data bit 0.
- R10: Word 0 holds the fields of pins 0 to 7 and word 1 those of pins 8 to 15. Pin n sits at bits [4(n mod 8)+3 : 4(n mod 8)]. Word 3 is the output data register, read and written directly.
- R11: Bus words 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access, 0 otherwise |
| pad_in | input | 16 | Pad levels |
| af_in | input | 16 | Alternate-function output values |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output value |
| pad_pu | output | 16 | Weak pull-up enable |
| pad_pd | output | 16 | Weak pull-down enable |
| pad_speed | output | 32 | Speed class, two bits per pin |

## Verification
The pin decoder is tried with all three speed codes on push-pull pins. It is also tried with an alternate-function pin whose af_in and data bit disagree, which separates the data source from the driver. Open-drain pins are driven from both sources with both values, which separates driving a 0 from releasing the pad. Input pins are set to pulled with both data values, and to analog, floating and the reserved code under an all-ones pad pattern. That shows which pins are masked, which get a pull, and the one-cycle capture latency. The set/clear register is written with mixed set, clear and conflicting bits and with all zeros. Unmapped words are written with all ones, which shows that nothing aliases.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Shared types for the GPIO port controller: the packed per-pin
// configuration field, the input-flavour codes and the reset presets.
// Assumes a field layout of direction/speed in bits [1:0] and
// flavour/driver in bits [3:2].
package gpio_port_pkg;

    typedef enum logic [1:0] {
        IN_ANALOG = 2'b00,
        IN_FLOAT  = 2'b01,
        IN_PULLED = 2'b10,
        IN_RSVD   = 2'b11
    } in_flavour_e;

    typedef struct packed {
        logic [1:0] cnf;
        logic [1:0] mode;
    } pin_cfg_t;

    localparam int CFG_W = 4;
    localparam int PINS_PER_CFG_WORD = 8;
    localparam int BUS_W = 32;

    localparam pin_cfg_t CFG_FLOAT_IN  = '{cnf: 2'b01, mode: 2'b00};
    localparam pin_cfg_t CFG_PULLED_IN = '{cnf: 2'b10, mode: 2'b00};

endpackage

// File: rtl/gpio_pin_ctrl.sv
// Module gpio_pin_ctrl
// Purely combinational decode of one pin's configuration field into
// pad controls. Assumes the caller supplies the pin's output data bit
// and alternate-function value. Produces an analog flag for input masking.
module gpio_pin_ctrl
    import gpio_port_pkg::*;
(
    input  pin_cfg_t   cfg,
    input  logic       data_bit,
    input  logic       af_bit,
    output logic       oe,
    output logic       out,
    output logic       pu,
    output logic       pd,
    output logic [1:0] speed,
    output logic       analog
);

    logic is_output;
    logic src_val;
    logic open_drain;

    // Decode direction, source and driver type
    always_comb begin
        is_output  = (cfg.mode != 2'b00);
        src_val    = cfg.cnf[1] ? af_bit : data_bit;
        open_drain = cfg.cnf[0];
    end

    // Drive pad controls for the selected mode
    always_comb begin
        oe     = 1'b0;
        out    = 1'b0;
        pu     = 1'b0;
        pd     = 1'b0;
        speed  = 2'b00;
        analog = 1'b0;
        if (is_output) begin
            speed = cfg.mode;
            if (open_drain) begin
                oe  = ~src_val;
                out = 1'b0;
            end else begin
                oe  = 1'b1;
                out = src_val;
            end
        end else begin
            case (in_flavour_e'(cfg.cnf))
                IN_ANALOG: analog = 1'b1;
                IN_PULLED: begin
                    pu = data_bit;
                    pd = ~data_bit;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sample.sv
// Module gpio_in_sample
// Captures pad levels into the input data register on every clock.
// Pins flagged analog are forced to 0. Assumes pad_in is already
// synchronous to clk, or that the pad model handles metastability.
module gpio_in_sample #(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] analog_mask,
    output logic [N_PINS-1:0] idr_q
);

    // Sample every cycle with the analog pins masked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idr_q <= '0;
        end else begin
            idr_q <= pad_in & ~analog_mask;
        end
    end

endmodule

// File: rtl/gpio_regbank.sv
// Module gpio_regbank
// Register file of the port: configuration words, output data and
// set/clear. Word map: configuration words first, then input data,
// output data and set/clear. Assumes N_PINS is a multiple of 8 and
// at most 16, so that set and clear fit in one 32-bit write.
module gpio_regbank
    import gpio_port_pkg::*;
#(
    parameter int                N_PINS     = 16,
    parameter int                ADDR_W     = 3,
    parameter logic [N_PINS-1:0] RST_PULLUP = '0,
    parameter logic [N_PINS-1:0] RST_PULLDN = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic [BUS_W-1:0]        bus_rdata,
    input  logic [N_PINS-1:0]       idr_q,
    output logic [N_PINS*CFG_W-1:0] cfg_flat,
    output logic [N_PINS-1:0]       odr_q
);

    localparam int N_CFG_WORDS = N_PINS / PINS_PER_CFG_WORD;
    localparam int ADR_IDR     = N_CFG_WORDS;
    localparam int ADR_ODR     = N_CFG_WORDS + 1;
    localparam int ADR_BSR     = N_CFG_WORDS + 2;

    // Compute the configuration reset image from the override masks
    function automatic logic [N_PINS*CFG_W-1:0] cfg_reset_image();
        logic [N_PINS*CFG_W-1:0] img;
        for (int p = 0; p < N_PINS; p++) begin
            if (RST_PULLUP[p] || RST_PULLDN[p]) begin
                img[p*CFG_W +: CFG_W] = CFG_PULLED_IN;
            end else begin
                img[p*CFG_W +: CFG_W] = CFG_FLOAT_IN;
            end
        end
        return img;
    endfunction

    localparam logic [N_PINS*CFG_W-1:0] CFG_RST = cfg_reset_image();

    logic                   wr_en;
    logic [N_PINS-1:0]      set_bits;
    logic [N_PINS-1:0]      clr_bits;

    // Split write strobes and the set/clear halves
    always_comb begin
        wr_en    = bus_sel && bus_wr;
        set_bits = bus_wdata[N_PINS-1:0];
        clr_bits = bus_wdata[2*N_PINS-1:N_PINS];
    end

    // Configuration words, one per group of eight pins
    for (genvar w = 0; w < N_CFG_WORDS; w++) begin : g_cfg_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_flat[w*BUS_W +: BUS_W] <= CFG_RST[w*BUS_W +: BUS_W];
            end else if (wr_en && bus_addr == ADDR_W'(w)) begin
                cfg_flat[w*BUS_W +: BUS_W] <= bus_wdata;
            end
        end
    end

    // Output data register with direct write and atomic set/clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odr_q <= RST_PULLUP;
        end else if (wr_en && bus_addr == ADDR_W'(ADR_ODR)) begin
            odr_q <= bus_wdata[N_PINS-1:0];
        end else if (wr_en && bus_addr == ADDR_W'(ADR_BSR)) begin
            odr_q <= (odr_q & ~clr_bits) | set_bits;
        end
    end

    // Read multiplexer; set/clear and unmapped words read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int w = 0; w < N_CFG_WORDS; w++) begin
                if (bus_addr == ADDR_W'(w)) begin
                    bus_rdata = cfg_flat[w*BUS_W +: BUS_W];
                end
            end
            if (bus_addr == ADDR_W'(ADR_IDR)) begin
                bus_rdata[N_PINS-1:0] = idr_q;
            end
            if (bus_addr == ADDR_W'(ADR_ODR)) begin
                bus_rdata[N_PINS-1:0] = odr_q;
            end
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// Module gpio_port_ctrl
// Top of the GPIO port controller: register bank, one decoder per pin
// and the input sampler. Assumes a single synchronous bus with
// single-cycle accesses and combinational read data.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int              N_PINS     = 16,
    parameter int              ADDR_W     = 3,
    parameter logic [15:0]     RST_PULLUP = 16'h0000,
    parameter logic [15:0]     RST_PULLDN = 16'h0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [N_PINS-1:0]   pad_in,
    input  logic [N_PINS-1:0]   af_in,
    output logic [N_PINS-1:0]   pad_oe,
    output logic [N_PINS-1:0]   pad_out,
    output logic [N_PINS-1:0]   pad_pu,
    output logic [N_PINS-1:0]   pad_pd,
    output logic [2*N_PINS-1:0] pad_speed
);

    logic [N_PINS*CFG_W-1:0] cfg_flat;
    logic [N_PINS-1:0]       odr_q;
    logic [N_PINS-1:0]       idr_q;
    logic [N_PINS-1:0]       analog_mask;

    gpio_regbank #(
        .N_PINS     (N_PINS),
        .ADDR_W     (ADDR_W),
        .RST_PULLUP (RST_PULLUP[N_PINS-1:0]),
        .RST_PULLDN (RST_PULLDN[N_PINS-1:0])
    ) u_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .idr_q     (idr_q),
        .cfg_flat  (cfg_flat),
        .odr_q     (odr_q)
    );

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        gpio_pin_ctrl u_pin (
            .cfg      (pin_cfg_t'(cfg_flat[p*CFG_W +: CFG_W])),
            .data_bit (odr_q[p]),
            .af_bit   (af_in[p]),
            .oe       (pad_oe[p]),
            .out      (pad_out[p]),
            .pu       (pad_pu[p]),
            .pd       (pad_pd[p]),
            .speed    (pad_speed[2*p +: 2]),
            .analog   (analog_mask[p])
        );
    end

    gpio_in_sample #(
        .N_PINS (N_PINS)
    ) u_in_sample (
        .clk         (clk),
        .rst_n       (rst_n),
        .pad_in      (pad_in),
        .analog_mask (analog_mask),
        .idr_q       (idr_q)
    );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
// Module gpio_port_ctrl_chk
// Assertion checker for gpio_port_ctrl, bound to the top below.
// Assumes the default 16-pin, 3-bit-address configuration.
module gpio_port_ctrl_chk #(
    parameter int N_PINS = 16,
    parameter int ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [N_PINS-1:0]   pad_in,
    input logic [N_PINS-1:0]   pad_oe,
    input logic [N_PINS-1:0]   pad_pu,
    input logic [N_PINS-1:0]   pad_pd,
    input logic [2*N_PINS-1:0] pad_speed,
    input logic [N_PINS-1:0]   odr_q,
    input logic [N_PINS-1:0]   idr_q,
    input logic [N_PINS-1:0]   analog_mask
);

    localparam logic [ADDR_W-1:0] ADR_BSR = ADDR_W'(N_PINS / 8 + 2);

    logic [N_PINS-1:0] out_pins;
    logic              bsr_wr;
    logic              bsr_rd;

    // Pins reported as outputs through their speed pair
    always_comb begin
        for (int p = 0; p < N_PINS; p++) begin
            out_pins[p] = (pad_speed[2*p +: 2] != 2'b00);
        end
        bsr_wr = bus_sel && bus_wr && bus_addr == ADR_BSR;
        bsr_rd = bus_sel && !bus_wr && bus_addr == ADR_BSR;
    end

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~out_pins) == '0); // R1

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0); // R5

    AST_OUT_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu | pad_pd) & out_pins) == '0); // R5

    AST_ANALOG_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu | pad_pd) & analog_mask) == '0); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> (odr_q & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])); // R7

    AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> (odr_q & $past(bus_wdata[2*N_PINS-1:N_PINS] & ~bus_wdata[N_PINS-1:0])) == '0); // R7

    AST_BSR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_rd |-> bus_rdata == 32'h0); // R7

    AST_IDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> idr_q == ($past(pad_in) & ~$past(analog_mask))); // R8

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .N_PINS (N_PINS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_pu      (pad_pu),
    .pad_pd      (pad_pd),
    .pad_speed   (pad_speed),
    .odr_q       (odr_q),
    .idr_q       (idr_q),
    .analog_mask (analog_mask)
);

// File: tb/test_gpio_port_ctrl.sv
// Directed bench for gpio_port_ctrl: one task per scenario.
module test_gpio_port_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] af_in = '0;
    logic [15:0] pad_oe, pad_out, pad_pu, pad_pd;
    logic [31:0] pad_speed;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gpio_port_ctrl #(
        .RST_PULLUP (16'h0003),
        .RST_PULLDN (16'h0010)
    ) i_gpio_port_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .af_in     (af_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd),
        .pad_speed (pad_speed)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write one word; the register updates at the edge inside the task
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R9 pull-up after reset", {16'h0, pad_pu}, 32'h0003);
        chk("R9 pull-down after reset", {16'h0, pad_pd}, 32'h0010);
        chk("R1 no drive after reset", {16'h0, pad_oe}, 32'h0);
        chk("R1 speed after reset", pad_speed, 32'h0);
        bus_read(3'd0, r); chk("R9 R10 config word 0", r, 32'h4448_4488);
        bus_read(3'd1, r); chk("R9 R10 config word 1", r, 32'h4444_4444);
        bus_read(3'd3, r); chk("R9 output data reset", r, 32'h0000_0003);
    endtask

    task automatic t_pushpull();
        bus_write(3'd0, 32'h4448_4213);
        bus_write(3'd3, 32'h0000_0005);
        chk("R2 push-pull enables", {29'h0, pad_oe[2:0]}, 32'h7);
        chk("R2 push-pull values", {29'h0, pad_out[2:0]}, 32'h5);
        chk("R1 speed classes", {26'h0, pad_speed[5:0]}, 32'h27);
        chk("R5 outputs lose pulls", {16'h0, pad_pu | pad_pd}, 32'h0010);
        bus_write(3'd3, 32'h0000_0002);
        chk("R2 push-pull follows data", {29'h0, pad_out[2:0]}, 32'h2);
    endtask

    task automatic t_altfunc();
        bus_write(3'd0, 32'h4448_9213);
        bus_write(3'd3, 32'h0000_0008);
        af_in = 16'h0000;
        @(negedge clk);
        chk("R3 af source low", {31'h0, pad_out[3]}, 32'h0);
        af_in = 16'h0008;
        @(negedge clk);
        chk("R3 af source high", {31'h0, pad_out[3]}, 32'h1);
        chk("R3 af speed", {30'h0, pad_speed[7:6]}, 32'h1);
        af_in = 16'h0000;
    endtask

    task automatic t_opendrain();
        bus_write(3'd0, 32'h4F68_9213);
        bus_write(3'd3, 32'h0000_0000);
        af_in = 16'h0040;
        @(negedge clk);
        chk("R4 od data 0 drives", {30'h0, pad_oe[5], pad_out[5]}, 32'h2);
        chk("R4 od af 1 released", {30'h0, pad_oe[6], pad_out[6]}, 32'h0);
        bus_write(3'd3, 32'h0000_0020);
        af_in = 16'h0000;
        @(negedge clk);
        chk("R4 od data 1 released", {30'h0, pad_oe[5], pad_out[5]}, 32'h0);
        chk("R4 od af 0 drives", {30'h0, pad_oe[6], pad_out[6]}, 32'h2);
    endtask

    task automatic t_pull();
        bus_write(3'd1, 32'h4444_4448);
        bus_write(3'd3, 32'h0000_0100);
        chk("R5 pull-up selected", {30'h0, pad_pu[8], pad_pd[8]}, 32'h2);
        bus_write(3'd3, 32'h0000_0000);
        chk("R5 pull-down selected", {30'h0, pad_pu[8], pad_pd[8]}, 32'h1);
    endtask

    task automatic t_inputs();
        logic [31:0] r;
        bus_write(3'd1, 32'h4444_4C08);
        @(negedge clk);
        pad_in = 16'hFFFF;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd2;
        #1 chk("R8 capture not yet visible", bus_rdata, 32'h0);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_read(3'd2, r); chk("R6 R8 input data with analog pin", r, 32'h0000_FDFF);
        chk("R6 analog and reserved no pull", {30'h0, pad_pu[9] | pad_pd[9], pad_pu[10] | pad_pd[10]}, 32'h0);
        pad_in = 16'h0400;
        bus_read(3'd2, r); chk("R6 reserved reads pad", r, 32'h0000_0400);
        pad_in = 16'h0000;
    endtask

    task automatic t_setclr();
        logic [31:0] r;
        bus_write(3'd3, 32'h0000_00F0);
        bus_write(3'd4, 32'h0030_0110);
        bus_read(3'd3, r); chk("R7 set clear and set wins", r, 32'h0000_01D0);
        bus_write(3'd4, 32'h0000_0000);
        bus_read(3'd3, r); chk("R7 zero write no change", r, 32'h0000_01D0);
        bus_read(3'd4, r); chk("R7 reads zero", r, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        for (int a = 5; a < 8; a++) begin
            bus_write(3'(a), 32'hFFFF_FFFF);
            bus_read(3'(a), r); chk("R11 unmapped reads zero", r, 32'h0);
        end
        bus_read(3'd0, r); chk("R11 config word 0 untouched", r, 32'h4F68_9213);
        bus_read(3'd1, r); chk("R11 config word 1 untouched", r, 32'h4444_4C08);
        bus_read(3'd3, r); chk("R11 output data untouched", r, 32'h0000_01D0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pushpull();
        t_altfunc();
        t_opendrain();
        t_pull();
        t_inputs();
        t_setclr();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule